// File: doc/BRIEF.md
# Colour Channel Auto-Cycle Selector

This block decides which of three colour channels (red, green or blue) is active in a line-scan imaging front end. The choice steers the input multiplexer and the per-colour offset and gain register multiplexers. It is reported as a 2-bit colour index, together with the 8-bit offset and 8-bit gain values that belong to the chosen colour.

The colour has one of two sources. With line-by-line mode on and auto-cycling enabled, a small state machine takes the colour. It steps red, green, blue and back to red on each rising edge of an external line-sync pin. The pin is first brought into the clock domain by a synchroniser. In every other configuration, a 2-bit register field names the colour directly. A one-cycle sequence-restart request returns the state machine to red. This lets software line up the cycle with the first line of a frame.

The auto-cycle state machine has three states. ST_RED moves to ST_GREEN, ST_GREEN moves to ST_BLUE, and ST_BLUE moves to ST_RED. Each of these transitions fires on a qualified pin edge. A fourth transition, the restart, leads from any state to ST_RED. Reset also puts the machine in ST_RED.

Top module: `colour_cycle_sel`

## Requirements
- R1: While rst_n is low, and after it is released with no other stimulus, the auto-cycle state is red. With auto mode active, colour_o is 2'b00 and ofs_o and gain_o carry the red register values.
- R2: With line_mode_i=1 and auto_en_i=1, colour_o follows the auto-cycle state. Each pin edge moves it red (2'b00), then green (2'b01), then blue (2'b10), then back to red. The value 2'b11 never appears on colour_o.
- R3: A rising level on cyc_pin_i shows on colour_o right after the third rising clk edge that samples the pin high. It does not show after the second.
- R4: A pin held high for many cycles advances the colour exactly once. The pin must be held high for at least two clock cycles and held low for at least two clock cycles between pulses.
- R5: With line_mode_i=1 and auto_en_i=0, colour_o is taken from int_sel_i: 2'b00 gives red, 2'b01 gives green and 2'b10 gives blue. The value changes with no clock edge.
- R6: With line_mode_i=0, auto_en_i has no effect. The colour comes from int_sel_i, and pin pulses do not move the auto-cycle state. The state is still unchanged when auto mode is later switched on.
- R7: If int_sel_i is 2'b11 while the register field is the source, colour_o is red (2'b00).
- R8: A high level on seq_restart_i at a rising clk edge puts the auto-cycle state at red. This takes priority over a pin edge taken at the same edge, and it applies in every mode.
- R9: ofs_o and gain_o always equal the offset and gain inputs of the colour shown on colour_o. They follow changes of those inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_mode_i | input | 1 | Line-by-line mode enable |
| auto_en_i | input | 1 | Auto-cycle enable (used only in line-by-line mode) |
| int_sel_i | input | 2 | Register colour select: 00 red, 01 green, 10 blue, 11 reserved |
| cyc_pin_i | input | 1 | Asynchronous line-sync pin |
| seq_restart_i | input | 1 | One-cycle request to restart the cycle at red |
| ofs_red_i | input | 8 | Red offset register value |
| ofs_green_i | input | 8 | Green offset register value |
| ofs_blue_i | input | 8 | Blue offset register value |
| gain_red_i | input | 8 | Red gain register value |
| gain_green_i | input | 8 | Green gain register value |
| gain_blue_i | input | 8 | Blue gain register value |
| colour_o | output | 2 | Selected colour index |
| ofs_o | output | 8 | Offset value of the selected colour |
| gain_o | output | 8 | Gain value of the selected colour |

## Verification
Short pin pulses step through the full red, green, blue sequence and the wrap back to red. A pulse whose edge-by-edge latency is checked separates the synchroniser depth from an off-by-one. A pin held high for a long time tells level counting apart from edge counting. A restart taken on its own is compared with a restart that arrives in the same cycle as a pin edge, which exposes the priority between the two. Pin pulses given with line-by-line mode off, and then with register selection on, show whether the mode gate really blocks the counter. All four register codes are tried, and the register values are changed under a fixed selection, to confirm that the value paths are combinational.

// File: rtl/colsel_pkg.sv
package colsel_pkg;
    typedef enum logic [1:0] {
        COL_RED   = 2'b00,
        COL_GREEN = 2'b01,
        COL_BLUE  = 2'b10,
        COL_RSVD  = 2'b11
    } colour_e;

    localparam int NUM_COLOURS = 3;
    localparam int COL_W       = 2;
endpackage

// File: rtl/colsel_sync_rise.sv
module colsel_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain plus one delay stage for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/colsel_cycle_fsm.sv
module colsel_cycle_fsm
    import colsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    advance_i,
    input  logic    restart_i,
    output colour_e colour_o
);
    typedef enum logic [1:0] {
        ST_RED   = 2'd0,
        ST_GREEN = 2'd1,
        ST_BLUE  = 2'd2
    } cyc_state_e;

    cyc_state_e state_q;
    cyc_state_e state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RED;
        end else begin
            state_q <= state_n;
        end
    end

    // Transitions: restart wins over an advance in the same cycle
    always_comb begin
        state_n = state_q;
        if (restart_i) begin
            state_n = ST_RED;
        end else if (advance_i) begin
            unique case (state_q)
                ST_RED:   state_n = ST_GREEN;
                ST_GREEN: state_n = ST_BLUE;
                ST_BLUE:  state_n = ST_RED;
                default:  state_n = ST_RED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RED:   colour_o = COL_RED;
            ST_GREEN: colour_o = COL_GREEN;
            ST_BLUE:  colour_o = COL_BLUE;
            default:  colour_o = COL_RED;
        endcase
    end
endmodule

// File: rtl/colsel_value_mux.sv
module colsel_value_mux
    import colsel_pkg::*;
#(
    parameter int VAL_W = 8,
    parameter int N     = NUM_COLOURS
) (
    input  logic [N-1:0][VAL_W-1:0] vals_i,
    input  colour_e                 sel_i,
    output logic [VAL_W-1:0]        val_o
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = (int'(sel_i) == g);
    end

    always_comb begin
        val_o = vals_i[0];
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                val_o = vals_i[i];
            end
        end
    end
endmodule

// File: rtl/colour_cycle_sel.sv
module colour_cycle_sel
    import colsel_pkg::*;
#(
    parameter int VAL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_mode_i,
    input  logic             auto_en_i,
    input  logic [1:0]       int_sel_i,
    input  logic             cyc_pin_i,
    input  logic             seq_restart_i,
    input  logic [VAL_W-1:0] ofs_red_i,
    input  logic [VAL_W-1:0] ofs_green_i,
    input  logic [VAL_W-1:0] ofs_blue_i,
    input  logic [VAL_W-1:0] gain_red_i,
    input  logic [VAL_W-1:0] gain_green_i,
    input  logic [VAL_W-1:0] gain_blue_i,
    output logic [1:0]       colour_o,
    output logic [VAL_W-1:0] ofs_o,
    output logic [VAL_W-1:0] gain_o
);
    logic    auto_act;
    logic    cyc_rise;
    colour_e cyc_colour;
    colour_e sel_colour;

    assign auto_act = line_mode_i & auto_en_i;

    colsel_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cyc_pin_i),
        .rise_o  (cyc_rise)
    );

    colsel_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (cyc_rise & auto_act),
        .restart_i (seq_restart_i),
        .colour_o  (cyc_colour)
    );

    // Source choice: state machine in auto mode, register field otherwise
    always_comb begin
        if (auto_act) begin
            sel_colour = cyc_colour;
        end else begin
            unique case (int_sel_i)
                2'b00:   sel_colour = COL_RED;
                2'b01:   sel_colour = COL_GREEN;
                2'b10:   sel_colour = COL_BLUE;
                default: sel_colour = COL_RED;
            endcase
        end
    end

    colsel_value_mux #(.VAL_W(VAL_W)) u_ofs_mux (
        .vals_i ({ofs_blue_i, ofs_green_i, ofs_red_i}),
        .sel_i  (sel_colour),
        .val_o  (ofs_o)
    );

    colsel_value_mux #(.VAL_W(VAL_W)) u_gain_mux (
        .vals_i ({gain_blue_i, gain_green_i, gain_red_i}),
        .sel_i  (sel_colour),
        .val_o  (gain_o)
    );

    assign colour_o = sel_colour;
endmodule

// File: rtl/colour_cycle_sel_chk.sv
module colour_cycle_sel_chk #(
    parameter int VAL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_mode_i,
    input logic             auto_en_i,
    input logic [1:0]       int_sel_i,
    input logic             seq_restart_i,
    input logic [VAL_W-1:0] ofs_red_i,
    input logic [VAL_W-1:0] ofs_green_i,
    input logic [VAL_W-1:0] ofs_blue_i,
    input logic [VAL_W-1:0] gain_red_i,
    input logic [VAL_W-1:0] gain_green_i,
    input logic [VAL_W-1:0] gain_blue_i,
    input logic [1:0]       colour_o,
    input logic [VAL_W-1:0] ofs_o,
    input logic [VAL_W-1:0] gain_o,
    input logic             cyc_rise,
    input logic [1:0]       cyc_colour
);
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode_i && auto_en_i && cyc_rise && !seq_restart_i) |=>
        (cyc_colour == (($past(cyc_colour) == 2'd2) ? 2'd0 : $past(cyc_colour) + 2'd1)));

    a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode_i && auto_en_i) |-> (colour_o == cyc_colour));

    a_r2_legal: assert property (@(posedge clk) disable iff (!rst_n)
        colour_o != 2'b11);

    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_rise |=> !cyc_rise);

    a_r5_manual: assert property (@(posedge clk) disable iff (!rst_n)
        (!(line_mode_i && auto_en_i) && int_sel_i != 2'b11) |-> (colour_o == int_sel_i));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(line_mode_i && auto_en_i) && !seq_restart_i) |=> $stable(cyc_colour));

    a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!(line_mode_i && auto_en_i) && int_sel_i == 2'b11) |-> (colour_o == 2'b00));

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart_i |=> (cyc_colour == 2'b00));

    a_r9_red_vals: assert property (@(posedge clk) disable iff (!rst_n)
        (colour_o == 2'b00) |-> (ofs_o == ofs_red_i && gain_o == gain_red_i));

    a_r9_green_vals: assert property (@(posedge clk) disable iff (!rst_n)
        (colour_o == 2'b01) |-> (ofs_o == ofs_green_i && gain_o == gain_green_i));

    a_r9_blue_vals: assert property (@(posedge clk) disable iff (!rst_n)
        (colour_o == 2'b10) |-> (ofs_o == ofs_blue_i && gain_o == gain_blue_i));
endmodule

bind colour_cycle_sel colour_cycle_sel_chk #(.VAL_W(VAL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_mode_i   (line_mode_i),
    .auto_en_i     (auto_en_i),
    .int_sel_i     (int_sel_i),
    .seq_restart_i (seq_restart_i),
    .ofs_red_i     (ofs_red_i),
    .ofs_green_i   (ofs_green_i),
    .ofs_blue_i    (ofs_blue_i),
    .gain_red_i    (gain_red_i),
    .gain_green_i  (gain_green_i),
    .gain_blue_i   (gain_blue_i),
    .colour_o      (colour_o),
    .ofs_o         (ofs_o),
    .gain_o        (gain_o),
    .cyc_rise      (cyc_rise),
    .cyc_colour    (cyc_colour)
);

// File: tb/colour_cycle_sel_tb.sv
module colour_cycle_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_mode_i, auto_en_i, cyc_pin_i, seq_restart_i;
    logic [1:0] int_sel_i;
    logic [7:0] ofs_red_i, ofs_green_i, ofs_blue_i;
    logic [7:0] gain_red_i, gain_green_i, gain_blue_i;
    logic [1:0] colour_o;
    logic [7:0] ofs_o, gain_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    colour_cycle_sel u_dut (
        .clk(clk), .rst_n(rst_n), .line_mode_i(line_mode_i), .auto_en_i(auto_en_i),
        .int_sel_i(int_sel_i), .cyc_pin_i(cyc_pin_i), .seq_restart_i(seq_restart_i),
        .ofs_red_i(ofs_red_i), .ofs_green_i(ofs_green_i), .ofs_blue_i(ofs_blue_i),
        .gain_red_i(gain_red_i), .gain_green_i(gain_green_i), .gain_blue_i(gain_blue_i),
        .colour_o(colour_o), .ofs_o(ofs_o), .gain_o(gain_o)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    function automatic logic [7:0] exp_ofs(logic [1:0] c);
        return (c == 2'b01) ? ofs_green_i : (c == 2'b10) ? ofs_blue_i : ofs_red_i;
    endfunction

    function automatic logic [7:0] exp_gain(logic [1:0] c);
        return (c == 2'b01) ? gain_green_i : (c == 2'b10) ? gain_blue_i : gain_red_i;
    endfunction

    // Checks colour index plus both value outputs against the expected colour.
    task automatic chk(string tag, logic [1:0] exp_c);
        #1;
        checks++;
        if (colour_o !== exp_c || ofs_o !== exp_ofs(exp_c) || gain_o !== exp_gain(exp_c)) begin
            failures++;
            $display("FAIL %s: colour=%b ofs=%h gain=%h expected colour=%b ofs=%h gain=%h",
                     tag, colour_o, ofs_o, gain_o, exp_c, exp_ofs(exp_c), exp_gain(exp_c));
        end
    endtask

    task automatic pin_pulse();
        cyc_pin_i = 1'b1;
        tick(3);
        cyc_pin_i = 1'b0;
        tick(3);
    endtask

    task automatic t_reset();
        line_mode_i = 1'b1; auto_en_i = 1'b1; int_sel_i = 2'b10;
        cyc_pin_i = 1'b0; seq_restart_i = 1'b0;
        ofs_red_i = 8'h11; ofs_green_i = 8'h22; ofs_blue_i = 8'h33;
        gain_red_i = 8'hA1; gain_green_i = 8'hA2; gain_blue_i = 8'hA3;
        rst_n = 1'b0;
        tick(3);
        chk("R1 in reset", 2'b00);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after release", 2'b00);
    endtask

    task automatic t_auto_cycle();
        pin_pulse(); chk("R2 red->green", 2'b01);
        pin_pulse(); chk("R2 green->blue", 2'b10);
        pin_pulse(); chk("R2 blue->red wrap", 2'b00);
    endtask

    task automatic t_latency();
        cyc_pin_i = 1'b1;
        tick(1); chk("R3 edge 1 no change", 2'b00);
        tick(1); chk("R3 edge 2 no change", 2'b00);
        tick(1); chk("R3 edge 3 changed", 2'b01);
        cyc_pin_i = 1'b0;
        tick(3);
    endtask

    task automatic t_long_high();
        cyc_pin_i = 1'b1;
        tick(20);
        chk("R4 long high counts once", 2'b10);
        cyc_pin_i = 1'b0;
        tick(3);
        chk("R4 falling edge no step", 2'b10);
    endtask

    task automatic t_restart();
        seq_restart_i = 1'b1; tick(1); seq_restart_i = 1'b0;
        chk("R8 restart to red", 2'b00);
        pin_pulse(); chk("R8 setup green", 2'b01);
        cyc_pin_i = 1'b1;
        tick(2);
        seq_restart_i = 1'b1; tick(1); seq_restart_i = 1'b0;
        chk("R8 restart beats edge", 2'b00);
        tick(4);
        chk("R8 no late step", 2'b00);
        cyc_pin_i = 1'b0;
        tick(3);
    endtask

    task automatic t_manual();
        pin_pulse(); // counter now green
        auto_en_i = 1'b0;
        int_sel_i = 2'b00; chk("R5 sel red", 2'b00);
        int_sel_i = 2'b10; chk("R5 sel blue", 2'b10);
        int_sel_i = 2'b01; chk("R5 sel green", 2'b01);
        int_sel_i = 2'b11; chk("R7 reserved gives red", 2'b00);
        int_sel_i = 2'b01;
        ofs_green_i = 8'h5A; gain_green_i = 8'hC3;
        chk("R9 live value follow", 2'b01);
        pin_pulse();
        auto_en_i = 1'b1;
        chk("R6 manual pulse ignored, counter still green", 2'b01);
        seq_restart_i = 1'b1; tick(1); seq_restart_i = 1'b0;
        chk("R8 restart in auto", 2'b00);
    endtask

    task automatic t_line_off();
        line_mode_i = 1'b0; auto_en_i = 1'b1; int_sel_i = 2'b10;
        chk("R6 auto_en ignored, sel blue", 2'b10);
        pin_pulse();
        pin_pulse();
        chk("R6 still blue after pulses", 2'b10);
        int_sel_i = 2'b11;
        chk("R7 reserved with line mode off", 2'b00);
        line_mode_i = 1'b1;
        chk("R6 counter untouched", 2'b00);
        pin_pulse();
        chk("R2 auto resumes", 2'b01);
    endtask

    initial begin
        t_reset();
        t_auto_cycle();
        t_latency();
        t_long_high();
        t_restart();
        t_manual();
        t_line_off();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule